// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block owns the 8-bit data address space of a small 8-bit controller. It takes one CPU access per cycle (an address, a write strobe with its data, and a flag that marks the access as a stack operation). It sends the access to one of several 128-byte RAM banks, to a sixteen-entry register file at the top of the space, to a program status word register, or to an unused region. The addressed byte comes back combinationally on the read bus.

The lower half of the space is banked. The bank number is taken from the last register of the register file, and that register file sits in the upper half, which stays reachable whatever bank is selected. Stack operations always land in bank 0. In bank 0 the sixteen bytes just under the midpoint are a hole that reads as all-ones, so a runaway stack pointer fetches an obviously invalid value. A separate enable turns banking off, and the top register then behaves as plain storage.

Top module: `banked_data_map`

## Requirements
- R1: After reset, every register-file location (0xF0 to 0xFF) and the status word at 0xEF read 0x00.
- R2: With banking on, a write to 0x00–0x7F (outside the bank-0 hole) stores into the selected bank. A later read of the same address in the same bank returns that byte. Each bank keeps its own contents.
- R3: The bank number is the low log2(NUM_BANKS) bits of the register at 0xFF (two bits by default). Its upper bits have no effect on which bank is used.
- R4: When stackAcc is 1, a low-half access uses bank 0 whatever the bank register holds.
- R5: When the effective bank is 0, reads of 0x70–0x7F return 0xFF and writes there are discarded. In banks 1 and up, those sixteen addresses are ordinary RAM.
- R6: Addresses 0xF0–0xFF are one register file that is read and written the same way for every bank setting.
- R7: Address 0xEF is a read/write status word register.
- R8: Reads of 0x80–0xEE return 0x00, and writes there change no stored value.
- R9: When bankEnable is 0, every low-half access uses bank 0, and 0xFF behaves as an ordinary register.
- R10: A write takes effect at the rising clock edge. In the cycle that the write is presented, the read bus still shows the old value of the addressed location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of register file and status word |
| addr | input | 8 | Data address of the current access |
| wrEn | input | 1 | Write strobe for the current access |
| wrData | input | 8 | Byte to write |
| stackAcc | input | 1 | Marks the access as a stack operation (forces bank 0) |
| bankEnable | input | 1 | Enables bank switching of the low half |
| rdData | output | 8 | Byte at the addressed location (combinational) |

## Verification
A wrong bank selection shows up as a byte from another bank, or as a spurious 0xFF, on the very next read of a low-half address. A stack access that follows the bank register overwrites data that a later non-stack read of another bank exposes. A corrupted register file or status word is visible as soon as that address is read, since reads are combinational. The bench therefore interleaves writes in several banks with readbacks under every combination of stack flag and banking enable. It also probes the write cycle itself to pin the edge timing.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BANK_BYTES = 128;
  localparam int OFFS_W = $clog2(BANK_BYTES);
  localparam int REG_COUNT = 16;
  localparam int REG_IDX_W = $clog2(REG_COUNT);
  localparam logic [ADDR_W-1:0] PSW_ADDR = 8'hEF;
  localparam logic [DATA_W-1:0] HOLE_VALUE = 8'hFF;
  localparam logic [DATA_W-1:0] UNUSED_VALUE = 8'h00;

  typedef enum logic [2:0] {
    RGN_RAM,
    RGN_HOLE,
    RGN_UNUSED,
    RGN_PSW,
    RGN_REG
  } region_e;

  typedef struct packed {
    logic    ramWr;
    logic    regWr;
    logic    pswWr;
    region_e region;
  } ctrl_s;
endpackage

// File: rtl/bdm_ctrl.sv
module bdm_ctrl
  import bdm_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              stackAcc,
  input  logic              bankEnable,
  input  logic [BANK_W-1:0] bankReg,
  output logic [BANK_W-1:0] bankSel,
  output ctrl_s             strobes
);
  logic lowHalf;
  logic inHoleWindow;
  logic isRegFile;
  logic useBankReg;
  region_e region;

  assign lowHalf      = ~addr[ADDR_W-1];
  assign inHoleWindow = (addr[ADDR_W-2:ADDR_W-4] == 3'b111);
  assign isRegFile    = (addr[ADDR_W-1:ADDR_W-4] == 4'hF);
  assign useBankReg   = bankEnable & ~stackAcc;
  assign bankSel      = useBankReg ? bankReg : '0;

  always_comb begin
    if (lowHalf) begin
      if ((bankSel == '0) && inHoleWindow) region = RGN_HOLE;
      else                                 region = RGN_RAM;
    end else if (addr == PSW_ADDR) begin
      region = RGN_PSW;
    end else if (isRegFile) begin
      region = RGN_REG;
    end else begin
      region = RGN_UNUSED;
    end
  end

  always_comb begin
    strobes.region = region;
    strobes.ramWr  = wrEn & (region == RGN_RAM);
    strobes.regWr  = wrEn & (region == RGN_REG);
    strobes.pswWr  = wrEn & (region == RGN_PSW);
  end
endmodule

// File: rtl/bdm_datapath.sv
module bdm_datapath
  import bdm_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BANK_W-1:0] bankSel,
  input  ctrl_s             strobes,
  output logic [BANK_W-1:0] bankReg,
  output logic [DATA_W-1:0] rdData
);
  localparam int RAM_DEPTH = NUM_BANKS * BANK_BYTES;
  localparam int RAM_IDX_W = BANK_W + OFFS_W;

  logic [DATA_W-1:0] ramArr [RAM_DEPTH];
  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [DATA_W-1:0] pswReg;
  logic [RAM_IDX_W-1:0] ramIdx;
  logic [REG_IDX_W-1:0] regIdx;

  assign ramIdx = {bankSel, addr[OFFS_W-1:0]};
  assign regIdx = addr[REG_IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobes.ramWr) ramArr[ramIdx] <= wrData;
  end

  genvar gi;
  generate
    for (gi = 0; gi < REG_COUNT; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[gi] <= '0;
        else if (strobes.regWr && (regIdx == REG_IDX_W'(gi))) regFile[gi] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pswReg <= '0;
    else if (strobes.pswWr) pswReg <= wrData;
  end

  assign bankReg = regFile[REG_COUNT-1][BANK_W-1:0];

  always_comb begin
    unique case (strobes.region)
      RGN_RAM:  rdData = ramArr[ramIdx];
      RGN_HOLE: rdData = HOLE_VALUE;
      RGN_PSW:  rdData = pswReg;
      RGN_REG:  rdData = regFile[regIdx];
      default:  rdData = UNUSED_VALUE;
    endcase
  end
endmodule

// File: rtl/banked_data_map.sv
module banked_data_map
  import bdm_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stackAcc,
  input  logic              bankEnable,
  output logic [DATA_W-1:0] rdData
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BANK_W-1:0] bankReg;
  logic [BANK_W-1:0] bankSel;
  ctrl_s strobes;

  bdm_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .addr(addr),
    .wrEn(wrEn),
    .stackAcc(stackAcc),
    .bankEnable(bankEnable),
    .bankReg(bankReg),
    .bankSel(bankSel),
    .strobes(strobes)
  );

  bdm_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .addr(addr),
    .wrData(wrData),
    .bankSel(bankSel),
    .strobes(strobes),
    .bankReg(bankReg),
    .rdData(rdData)
  );
endmodule

// File: rtl/bdm_checker.sv
module bdm_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] addr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       stackAcc,
  input logic       bankEnable,
  input logic [7:0] rdData
);
  logic [1:0] liveCnt;
  logic histOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveCnt <= '0;
    else if (liveCnt != 2'd3) liveCnt <= liveCnt + 2'd1;
  end
  assign histOk = (liveCnt >= 2'd2);

  // R5
  hole_reads_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((addr[7:4] == 4'h7) && (stackAcc || !bankEnable)) |-> (rdData == 8'hFF));

  // R8
  unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((addr >= 8'h80) && (addr <= 8'hEE)) |-> (rdData == 8'h00));

  // R7
  psw_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && $past(wrEn && (addr == 8'hEF)) && (addr == 8'hEF)) |-> (rdData == $past(wrData)));

  // R6
  reg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && $past(wrEn && (addr[7:4] == 4'hF)) && (addr == $past(addr)))
      |-> (rdData == $past(wrData)));

  // R10
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && !$past(wrEn) && $stable(addr) && $stable(stackAcc) && $stable(bankEnable)
      && !$isunknown(rdData)) |-> $stable(rdData));
endmodule

bind banked_data_map bdm_checker u_chk (
  .clk(clk),
  .rstN(rstN),
  .addr(addr),
  .wrEn(wrEn),
  .wrData(wrData),
  .stackAcc(stackAcc),
  .bankEnable(bankEnable),
  .rdData(rdData)
);

// File: tb/banked_data_map_bench.sv
`timescale 1ns/1ps
module banked_data_map_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       stackAcc = 1'b0;
  logic       bankEnable = 1'b0;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t expQ[$];
  event monEv;

  always #4 clk = ~clk;

  banked_data_map u_banked_data_map (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .stackAcc(stackAcc), .bankEnable(bankEnable), .rdData(rdData)
  );

  // monitor: pops expected items and compares against the read bus
  initial begin
    forever begin
      @(monEv);
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        nChecks++;
        if (rdData !== it.exp) begin
          nFail++;
          $display("FAIL %s: addr=%02h rdData=%02h expected %02h", it.tag, addr, rdData, it.exp);
        end
      end
    end
  end

  task automatic expectNow(input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    expQ.push_back(it);
    ->monEv;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stk = 1'b0);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; stackAcc = stk;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag,
                    input logic stk = 1'b0);
    @(negedge clk);
    addr = a; wrEn = 1'b0; stackAcc = stk;
    #1;
    expectNow(exp, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(8'hF0, 8'h00, "R1");
    rd(8'hFD, 8'h00, "R1");
    rd(8'hFF, 8'h00, "R1");
    rd(8'hEF, 8'h00, "R1");

    // R7 status word
    wr(8'hEF, 8'h5A);
    rd(8'hEF, 8'h5A, "R7");

    // R6 register file
    for (int i = 0; i < 15; i++) wr(8'hF0 + 8'(i), 8'h40 + 8'(i));
    for (int i = 0; i < 15; i++) rd(8'hF0 + 8'(i), 8'h40 + 8'(i), "R6");

    // R9 banking disabled
    bankEnable = 1'b0;
    wr(8'hFF, 8'h03);
    wr(8'h10, 8'hAA);
    rd(8'h10, 8'hAA, "R9");
    bankEnable = 1'b1;
    wr(8'h10, 8'hBB);
    rd(8'h10, 8'hBB, "R2");
    bankEnable = 1'b0;
    rd(8'h10, 8'hAA, "R9");
    rd(8'hFF, 8'h03, "R9");

    // R2 independent banks
    bankEnable = 1'b1;
    for (int b = 0; b < 4; b++) begin
      wr(8'hFF, 8'(b));
      wr(8'h20, 8'h10 + 8'(b));
    end
    for (int b = 3; b >= 0; b--) begin
      wr(8'hFF, 8'(b));
      rd(8'h20, 8'h10 + 8'(b), "R2");
    end
    // R6 register file visible from bank 3
    wr(8'hFF, 8'h03);
    rd(8'hF1, 8'h41, "R6");
    rd(8'hEF, 8'h5A, "R7");

    // R3 upper bank-register bits ignored
    wr(8'hFF, 8'hF6);
    rd(8'h20, 8'h12, "R3");
    wr(8'hFF, 8'hFD);
    rd(8'h20, 8'h11, "R3");

    // R4 stack pinned to bank 0
    wr(8'hFF, 8'h02);
    wr(8'h05, 8'h33, 1'b0);
    wr(8'h05, 8'h77, 1'b1);
    rd(8'h05, 8'h77, "R4", 1'b1);
    rd(8'h05, 8'h33, "R4", 1'b0);
    rd(8'h75, 8'hFF, "R5", 1'b1);

    // R5 hole in bank 0 only
    wr(8'hFF, 8'h00);
    rd(8'h75, 8'hFF, "R5");
    wr(8'h75, 8'h12);
    rd(8'h75, 8'hFF, "R5");
    wr(8'hFF, 8'h01);
    wr(8'h7F, 8'h44);
    rd(8'h7F, 8'h44, "R5");
    bankEnable = 1'b0;
    rd(8'h7F, 8'hFF, "R5");
    bankEnable = 1'b1;
    rd(8'h7F, 8'h44, "R5");

    // R8 unused region
    wr(8'h90, 8'h55);
    rd(8'h90, 8'h00, "R8");
    rd(8'h80, 8'h00, "R8");
    wr(8'hEE, 8'h66);
    rd(8'hEE, 8'h00, "R8");
    rd(8'hEF, 8'h5A, "R8");
    rd(8'hF0, 8'h40, "R8");

    // R10 write visible only after the edge
    @(negedge clk);
    addr = 8'hF3; wrData = 8'hC3; wrEn = 1'b1; stackAcc = 1'b0;
    #1;
    expectNow(8'h43, "R10");
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    expectNow(8'hC3, "R10");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule